// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block gathers interrupt requests from a parameterized set of sources, numbered 1 to `NUM_SRC`. It delivers them to `NUM_CTX` target contexts, each of which drives one level interrupt line toward a processor. ID 0 is reserved and never names a real source. Software programs the block over a simple single-cycle register bus:

- a 3-bit priority for each source;
- an enable bit per source for each context;
- a 3-bit threshold for each context;
- a claim/complete register for each context.

A source reaches a context only when four conditions all hold: it is pending, it is enabled for that context, its priority is nonzero, and its priority is strictly above that context's threshold.

Each source enters through a gateway, a three-state machine with the states `GW_IDLE`, `GW_PENDING` and `GW_INSERV`. Three transitions move between them:

- `T_REQ` goes from idle to pending when a request is seen. For a level source the request is the line being high. For an edge source it is a rising edge of the line.
- `T_CLAIM` goes from pending to in-service when a context claims the source.
- `T_DONE` goes from in-service back to idle when the source's ID is written back as a completion.

While a source is pending or in service, its gateway accepts no new request. Sources with ID at or above `EDGE_FIRST` use the rising-edge gateway. All others use the level gateway.

Reading a context's claim register returns the best eligible ID: highest priority first, and the lowest ID among equal priorities. The same read moves that source into service. A read that returns 0 means that nothing eligible is pending. The read result appears on `rdata_o` in the cycle after the read strobe. Each context output `irq_o` is registered. It is high in the cycle after an eligible source exists.

Top module: `pic_core`

## Requirements
- R1: After reset, all priorities, enables and thresholds read as 0, both interrupt outputs are low, and a claim read returns 0.
- R2: The priority of source ID sits at byte address 4×ID for ID 1..NUM_SRC. Only bits [2:0] are stored, and the upper bits read as 0. Address 0 (ID 0) reads as 0, and writes to it are ignored.
- R3: The enable word for context c is at 0x2000 + 0x80×c (word k at +4×k). Bit (ID mod 32) of word (ID / 32) enables source ID. Bit 0 of word 0 always reads as 0.
- R4: The threshold for context c is at 0x200000 + 0x1000×c, stored in bits [2:0]. The claim/complete register for context c is at the same base + 4.
- R5: A source is eligible for a context only if it is pending, enabled for that context, and its priority is strictly greater than the context threshold. A source with priority 0 stays pending but is never delivered.
- R6: A claim read returns the eligible ID with the highest priority; among equal priorities it returns the lowest ID. When nothing is eligible it returns 0.
- R7: A claim that returns a nonzero ID moves that source out of pending, so no context can claim it again until it is completed.
- R8: Writing an ID to a claim/complete register completes that source only if it is in service. Values of 0, values above NUM_SRC, and IDs not in service are ignored.
- R9: A level source whose line is high while idle becomes pending. If its line is still high at completion, it becomes pending again. If the line is low, it stays idle.
- R10: An edge source becomes pending once per rising edge seen while idle. Rising edges while it is pending or in service are dropped, and a line held high yields only one request.
- R11: `irq_o[c]` rises in the cycle after a source becomes eligible for context c. It falls in the cycle after the last eligible source is claimed.
- R12: Reads of unimplemented addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_src_i | input | NUM_SRC | Interrupt request lines for sources 1..NUM_SRC |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read strobe, 0 otherwise |
| irq_o | output | NUM_CTX | Per-context interrupt request toward the processor |

## Verification
A full sweep of one source's priority against one context's threshold, over all 64 pairs, separates a strict comparison from a non-strict one. It also shows the effect of priority 0.

Fifteen level sources with repeating priorities are raised together and then drained by alternating claims from the two contexts. The bench computes the claim order with its own model, so a wrong tie-break or a double hand-out between contexts shows up as an order mismatch.

Level and edge gateways are each driven through held lines, repeated pulses, and completion writes with bad or stale IDs. These cases tell re-arming apart from dropped requests. A cycle-exact probe of `irq_o` around a raise and a claim pins down the one-register delay on the output.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int DATA_W      = 32;
    localparam int EN_BASE     = 32'h0000_2000;
    localparam int EN_STRIDE   = 32'h0000_0080;
    localparam int CTX_BASE    = 32'h0020_0000;
    localparam int CTX_STRIDE  = 32'h0000_1000;
    localparam int THR_OFF     = 0;
    localparam int CLAIM_OFF   = 4;

    typedef enum logic [1:0] {
        GW_IDLE    = 2'd0,
        GW_PENDING = 2'd1,
        GW_INSERV  = 2'd2
    } gw_state_e;

endpackage

// File: rtl/pic_gateway.sv
module pic_gateway
    import pic_pkg::*;
#(
    parameter bit EDGE = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic irq_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pending_o
);

    gw_state_e state_q, state_d;
    logic      req;

    // Request detection variant chosen by parameter
    if (EDGE) begin : g_edge
        logic irq_q;
        always_ff @(posedge clk_i) begin
            if (!rst_ni) irq_q <= 1'b0;
            else         irq_q <= irq_i;
        end
        assign req = irq_i & ~irq_q;

        p_edge_take_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (state_q == GW_IDLE && irq_i && !irq_q) |=> state_q == GW_PENDING);
        p_edge_flat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (state_q == GW_IDLE && !(irq_i && !irq_q)) |=> state_q == GW_IDLE);
    end else begin : g_level
        assign req = irq_i;

        p_level_take_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (state_q == GW_IDLE && irq_i) |=> state_q == GW_PENDING);
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= GW_IDLE;
        else         state_q <= state_d;
    end

    // Next-state logic: T_REQ, T_CLAIM, T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE:    if (req)        state_d = GW_PENDING;
            GW_PENDING: if (claim_i)    state_d = GW_INSERV;
            GW_INSERV:  if (complete_i) state_d = GW_IDLE;
            default:                    state_d = GW_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pending_o = (state_q == GW_PENDING);
    end

    p_claim_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        claim_i |-> state_q == GW_PENDING);
    p_serv_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == GW_INSERV && !complete_i) |=> state_q == GW_INSERV);

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 31,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = $clog2(NUM_SRC + 1)
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic [NUM_SRC:1]                pend_i,
    input  logic [NUM_SRC:1]                en_i,
    input  logic [NUM_SRC:1][PRIO_W-1:0]    prio_i,
    input  logic [PRIO_W-1:0]               thr_i,
    output logic [ID_W-1:0]                 best_id_o,
    output logic                            valid_o
);

    logic [NUM_SRC:1]  elig;
    logic [PRIO_W-1:0] best_prio;

    always_comb begin
        for (int i = 1; i <= NUM_SRC; i++) begin
            elig[i] = pend_i[i] && en_i[i] && (prio_i[i] > thr_i);
        end
    end

    // Scan from the top ID down; ">=" lets the lower ID take equal priority
    always_comb begin
        best_id_o = '0;
        best_prio = '0;
        for (int i = NUM_SRC; i >= 1; i--) begin
            if (elig[i] && prio_i[i] >= best_prio) begin
                best_id_o = ID_W'(i);
                best_prio = prio_i[i];
            end
        end
        valid_o = |elig;
    end

    p_win_elig_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (pend_i[best_id_o] && en_i[best_id_o] && prio_i[best_id_o] > thr_i));

    for (genvar g = 1; g <= NUM_SRC; g++) begin : g_chk
        p_win_top_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            elig[g] |-> ((prio_i[g] < best_prio) ||
                         ((prio_i[g] == best_prio) && (ID_W'(g) >= best_id_o))));
    end

endmodule

// File: rtl/pic_regfile.sv
module pic_regfile
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 31,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 24,
    parameter int ID_W    = $clog2(NUM_SRC + 1)
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                wr_en_i,
    input  logic                                rd_en_i,
    input  logic [ADDR_W-1:0]                   addr_i,
    input  logic [DATA_W-1:0]                   wdata_i,
    output logic [DATA_W-1:0]                   rdata_o,
    input  logic [NUM_CTX-1:0][ID_W-1:0]        best_id_i,
    input  logic [NUM_CTX-1:0]                  best_valid_i,
    output logic [NUM_SRC:1][PRIO_W-1:0]        prio_o,
    output logic [NUM_CTX-1:0][NUM_SRC:1]       en_o,
    output logic [NUM_CTX-1:0][PRIO_W-1:0]      thr_o,
    output logic [NUM_SRC:1]                    claim_o,
    output logic [NUM_SRC:1]                    complete_o
);

    localparam int EN_WORDS = (NUM_SRC + 32) / 32;
    localparam int EN_BITS  = EN_WORDS * 32;

    function automatic logic [EN_BITS-1:0] keep_mask();
        logic [EN_BITS-1:0] m;
        m = '0;
        for (int i = 1; i <= NUM_SRC; i++) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [EN_BITS-1:0] EN_KEEP = keep_mask();

    logic [NUM_SRC:1][PRIO_W-1:0]          prio_q;
    logic [NUM_CTX-1:0][EN_BITS-1:0]       en_q;
    logic [NUM_CTX-1:0][PRIO_W-1:0]        thr_q;
    logic [DATA_W-1:0]                     rdata_q;

    logic                                  prio_hit;
    logic [ID_W-1:0]                       prio_idx;
    logic [NUM_CTX-1:0][EN_WORDS-1:0]      en_hit;
    logic [NUM_CTX-1:0]                    thr_hit;
    logic [NUM_CTX-1:0]                    clm_hit;
    logic [DATA_W-1:0]                     rd_val;
    logic                                  id_ok;

    // Address decode
    always_comb begin
        prio_hit = (addr_i[1:0] == 2'b00) && (addr_i < ADDR_W'(4 * (NUM_SRC + 1)));
        prio_idx = ID_W'(addr_i >> 2);
        for (int c = 0; c < NUM_CTX; c++) begin
            for (int w = 0; w < EN_WORDS; w++) begin
                en_hit[c][w] = (addr_i == ADDR_W'(EN_BASE + c * EN_STRIDE + 4 * w));
            end
            thr_hit[c] = (addr_i == ADDR_W'(CTX_BASE + c * CTX_STRIDE + THR_OFF));
            clm_hit[c] = (addr_i == ADDR_W'(CTX_BASE + c * CTX_STRIDE + CLAIM_OFF));
        end
    end

    // Read mux
    always_comb begin
        rd_val = '0;
        if (prio_hit && prio_idx != '0) rd_val = DATA_W'(prio_q[prio_idx]);
        for (int c = 0; c < NUM_CTX; c++) begin
            for (int w = 0; w < EN_WORDS; w++) begin
                if (en_hit[c][w]) rd_val = en_q[c][w*32 +: 32];
            end
            if (thr_hit[c]) rd_val = DATA_W'(thr_q[c]);
            if (clm_hit[c]) rd_val = best_valid_i[c] ? DATA_W'(best_id_i[c]) : '0;
        end
    end

    // Claim and completion pulses toward the gateways
    always_comb begin
        id_ok      = (wdata_i >= DATA_W'(1)) && (wdata_i <= DATA_W'(NUM_SRC));
        claim_o    = '0;
        complete_o = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            if (rd_en_i && clm_hit[c] && best_valid_i[c]) claim_o[best_id_i[c]] = 1'b1;
            if (wr_en_i && clm_hit[c] && id_ok) complete_o[wdata_i[ID_W-1:0]] = 1'b1;
        end
    end

    // Register storage
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            prio_q  <= '0;
            en_q    <= '0;
            thr_q   <= '0;
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_en_i ? rd_val : '0;
            if (wr_en_i) begin
                if (prio_hit && prio_idx != '0) prio_q[prio_idx] <= wdata_i[PRIO_W-1:0];
                for (int c = 0; c < NUM_CTX; c++) begin
                    for (int w = 0; w < EN_WORDS; w++) begin
                        if (en_hit[c][w]) en_q[c][w*32 +: 32] <= wdata_i & EN_KEEP[w*32 +: 32];
                    end
                    if (thr_hit[c]) thr_q[c] <= wdata_i[PRIO_W-1:0];
                end
            end
        end
    end

    always_comb begin
        prio_o  = prio_q;
        thr_o   = thr_q;
        rdata_o = rdata_q;
        for (int c = 0; c < NUM_CTX; c++) en_o[c] = en_q[c][NUM_SRC:1];
    end

    p_claim_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(claim_o));
    p_thr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(thr_q));

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_chk
        p_claim_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rd_en_i && clm_hit[c] && !best_valid_i[c]) |=> rdata_o == '0);
    end

endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
#(
    parameter int NUM_SRC    = 31,
    parameter int NUM_CTX    = 2,
    parameter int PRIO_W     = 3,
    parameter int ADDR_W     = 24,
    parameter int EDGE_FIRST = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_SRC:1]    irq_src_i,
    input  logic                wr_en_i,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [31:0]         wdata_i,
    output logic [31:0]         rdata_o,
    output logic [NUM_CTX-1:0]  irq_o
);

    localparam int ID_W = $clog2(NUM_SRC + 1);

    logic [NUM_SRC:1]                 pend;
    logic [NUM_SRC:1]                 claim;
    logic [NUM_SRC:1]                 complete;
    logic [NUM_SRC:1][PRIO_W-1:0]     prio;
    logic [NUM_CTX-1:0][NUM_SRC:1]    en;
    logic [NUM_CTX-1:0][PRIO_W-1:0]   thr;
    logic [NUM_CTX-1:0][ID_W-1:0]     best_id;
    logic [NUM_CTX-1:0]               best_valid;
    logic [NUM_CTX-1:0]               irq_q;

    pic_regfile #(
        .NUM_SRC (NUM_SRC),
        .NUM_CTX (NUM_CTX),
        .PRIO_W  (PRIO_W),
        .ADDR_W  (ADDR_W),
        .ID_W    (ID_W)
    ) u_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_en_i      (wr_en_i),
        .rd_en_i      (rd_en_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .rdata_o      (rdata_o),
        .best_id_i    (best_id),
        .best_valid_i (best_valid),
        .prio_o       (prio),
        .en_o         (en),
        .thr_o        (thr),
        .claim_o      (claim),
        .complete_o   (complete)
    );

    for (genvar g = 1; g <= NUM_SRC; g++) begin : g_gw
        pic_gateway #(
            .EDGE (g >= EDGE_FIRST)
        ) u_gw (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .irq_i      (irq_src_i[g]),
            .claim_i    (claim[g]),
            .complete_i (complete[g]),
            .pending_o  (pend[g])
        );
    end

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        pic_arbiter #(
            .NUM_SRC (NUM_SRC),
            .PRIO_W  (PRIO_W),
            .ID_W    (ID_W)
        ) u_arb (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .pend_i    (pend),
            .en_i      (en[c]),
            .prio_i    (prio),
            .thr_i     (thr[c]),
            .best_id_o (best_id[c]),
            .valid_o   (best_valid[c])
        );
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) irq_q <= '0;
        else         irq_q <= best_valid;
    end

    assign irq_o = irq_q;

endmodule

// File: tb/sim_pic_core.sv
module sim_pic_core;

    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] CLM0 = 24'h200004;
    localparam logic [23:0] CLM1 = 24'h201004;
    localparam logic [23:0] THR0 = 24'h200000;
    localparam logic [23:0] THR1 = 24'h201000;
    localparam logic [23:0] EN0  = 24'h002000;
    localparam logic [23:0] EN1  = 24'h002080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:1] irq_src = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [23:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    int prio_m[32];

    always #(CLK_PERIOD / 2) clk = ~clk;

    pic_core u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .irq_src_i (irq_src),
        .wr_en_i   (wr_en),
        .rd_en_i   (rd_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [23:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int id);
        @(negedge clk); irq_src[id] = 1'b1;
        @(negedge clk); irq_src[id] = 1'b0;
    endtask

    function automatic int pick(input logic [31:0] rem);
        int best = 0;
        int bp = 0;
        for (int i = 1; i < 32; i++) begin
            if (rem[i] && prio_m[i] > 0 && (best == 0 || prio_m[i] > bp)) begin
                best = i; bp = prio_m[i];
            end
        end
        return best;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] rem;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1 irq_o", {30'd0, irq_o}, 32'd0);
        for (int id = 1; id < 32; id++) begin
            rd(24'(4 * id), d); chk("R1 prio", d, 32'd0);
        end
        rd(EN0, d);  chk("R1 en0", d, 0);
        rd(EN1, d);  chk("R1 en1", d, 0);
        rd(THR0, d); chk("R1 thr0", d, 0);
        rd(CLM0, d); chk("R1 claim", d, 0);

        // R2 priority storage sweep
        for (int id = 0; id < 32; id++) begin
            wr(24'(4 * id), 32'hFFFF_FFF8 | 32'((id * 3 + 1) % 8));
        end
        for (int id = 0; id < 32; id++) begin
            rd(24'(4 * id), d);
            chk("R2 prio readback", d, id == 0 ? 32'd0 : 32'((id * 3 + 1) % 8));
        end

        // R3 enables, R4 thresholds
        wr(EN0, 32'hFFFF_FFFF); rd(EN0, d); chk("R3 en0", d, 32'hFFFF_FFFE);
        wr(EN1, 32'hA5A5_A5A5); rd(EN1, d); chk("R3 en1", d, 32'hA5A5_A5A4);
        rd(EN0, d); chk("R3 en0 separate", d, 32'hFFFF_FFFE);
        wr(THR0, 32'hFFFF_FFFD); rd(THR0, d); chk("R4 thr0", d, 5);
        wr(THR1, 32'h2);         rd(THR1, d); chk("R4 thr1", d, 2);

        // R12 unmapped reads
        rd(24'h000080, d); chk("R12 0x80", d, 0);
        rd(24'h002004, d); chk("R12 0x2004", d, 0);
        rd(24'h002100, d); chk("R12 0x2100", d, 0);
        rd(24'h200008, d); chk("R12 0x200008", d, 0);
        rd(24'h202000, d); chk("R12 0x202000", d, 0);

        // clear configuration
        for (int id = 1; id < 32; id++) wr(24'(4 * id), 0);
        wr(EN0, 0); wr(EN1, 0); wr(THR0, 0); wr(THR1, 0);

        // R5 priority vs threshold sweep on source 3
        wr(EN0, 32'h8);
        irq_src[3] = 1'b1;
        for (int p = 0; p < 8; p++) begin
            for (int t = 0; t < 8; t++) begin
                wr(24'd12, 32'(p));
                wr(THR0, 32'(t));
                idle(2);
                chk($sformatf("R5 p%0d t%0d", p, t), {31'd0, irq_o[0]}, {31'd0, p > t});
            end
        end
        chk("R5 ctx1 not enabled", {31'd0, irq_o[1]}, 0);
        wr(THR0, 0); wr(24'd12, 1);
        rd(CLM0, d); chk("R6 single claim", d, 3);
        irq_src[3] = 1'b0;
        wr(CLM0, 3);
        idle(2);
        rd(CLM0, d); chk("R9 level low after done", d, 0);
        wr(24'd12, 0);

        // R6/R7 arbitration with alternating contexts
        for (int i = 0; i < 32; i++) prio_m[i] = 0;
        for (int id = 1; id <= 15; id++) begin
            prio_m[id] = (id * 5) % 8;
            wr(24'(4 * id), 32'(prio_m[id]));
        end
        wr(EN0, 32'hFFFF_FFFE); wr(EN1, 32'hFFFF_FFFE);
        irq_src[15:1] = '1;
        idle(2);
        rem = 32'h0000_FFFE;
        for (int k = 0; k < 16; k++) begin
            int e;
            e = pick(rem);
            rd(k % 2 == 0 ? CLM0 : CLM1, d);
            chk($sformatf("R6 R7 claim %0d", k), d, 32'(e));
            if (e != 0) rem[e] = 1'b0;
        end
        irq_src[15:1] = '0;
        for (int id = 1; id <= 15; id++) wr(CLM0, 32'(id));
        idle(2);
        chk("R5 prio0 held back", {30'd0, irq_o}, 0);
        wr(24'd32, 1);
        rd(CLM1, d); chk("R5 prio0 source still pending", d, 8);
        wr(CLM1, 8);
        wr(24'd32, 0);
        idle(2);
        chk("R11 irq low after drain", {30'd0, irq_o}, 0);

        // R8/R9 completion rules on level source 2 (prio 2)
        irq_src[2] = 1'b1;
        idle(2);
        rd(CLM0, d); chk("R9 level claim", d, 2);
        wr(CLM0, 5);  rd(CLM0, d); chk("R8 stale id ignored", d, 0);
        wr(CLM0, 40); rd(CLM0, d); chk("R8 out of range ignored", d, 0);
        wr(CLM0, 0);  rd(CLM0, d); chk("R8 zero ignored", d, 0);
        wr(CLM0, 2);  idle(2);
        rd(CLM0, d); chk("R9 level re-pend", d, 2);
        irq_src[2] = 1'b0;
        wr(CLM0, 2); idle(2);
        rd(CLM0, d); chk("R9 level idle", d, 0);

        // R10 edge gateway on source 20
        wr(24'd80, 5);
        pulse(20); idle(1);
        rd(CLM0, d); chk("R10 edge claim", d, 20);
        rd(CLM0, d); chk("R10 one claim per edge", d, 0);
        pulse(20);
        wr(CLM0, 20); idle(2);
        rd(CLM0, d); chk("R10 edge in service dropped", d, 0);
        pulse(20); pulse(20); idle(1);
        rd(CLM0, d); chk("R10 edge claim 2", d, 20);
        wr(CLM0, 20); idle(2);
        rd(CLM0, d); chk("R10 edge while pending dropped", d, 0);
        @(negedge clk); irq_src[20] = 1'b1;
        idle(2);
        rd(CLM0, d); chk("R10 held edge claim", d, 20);
        wr(CLM0, 20); idle(3);
        rd(CLM0, d); chk("R10 held line single request", d, 0);
        irq_src[20] = 1'b0;
        pulse(20); idle(1);
        rd(CLM1, d); chk("R10 new edge after release", d, 20);
        wr(CLM1, 20);

        // R11 output timing on source 4 (prio 4)
        idle(2);
        @(negedge clk); irq_src[4] = 1'b1;
        @(negedge clk); chk("R11 one edge after raise", {31'd0, irq_o[0]}, 0);
        @(negedge clk); chk("R11 two edges after raise", {31'd0, irq_o[0]}, 1);
        chk("R11 ctx1 too", {31'd0, irq_o[1]}, 1);
        rd(CLM0, d); chk("R6 claim 4", d, 4);
        chk("R11 still high at claim edge", {31'd0, irq_o[0]}, 1);
        @(negedge clk); chk("R11 low after claim", {30'd0, irq_o}, 0);
        irq_src[4] = 1'b0;
        wr(CLM0, 4);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule